// File: doc/BRIEF.md
# Symmetric Wavelet Low-Pass Filter Stage

This block is the low-pass half of one level of a one-dimensional discrete wavelet transform, built for a stream of 8-bit samples. Each accepted sample enters a nine-sample window. For the window centred on sample x, the block adds each mirrored pair of neighbours (x−k, x+k for k = 1..4) before any multiplication. It scales the pairs and the centre by five unsigned coefficients, sums the products and emits one result for every second window position. This is decimation by two.

Two options shape the quantisation error. The first is zero substitution: the lowest input bit is forced to zero before use, which saves multiplier input bits downstream. Its cost is an error that is always one-sided: the exact result minus the result lies between 0 and the coefficient weight sum (4585 with the default coefficients). The second option adds a constant after the final sum. This "active renormalisation" shifts that one-sided error towards zero. A fixed bias of 2048 is offered. A half-span bias (2292 by default) is also offered, which makes the error range almost symmetric about zero.

Top module: `dwt_lowpass`

## Requirements
- R1: After a synchronous active-low reset, out_valid is low, and no output is produced until nine samples have been accepted since reset.
- R2: With zsub_en low and bias_sel = 2'b00, each output equals 1517·D(x) + 853·(D(x−1)+D(x+1)) + 402·(D(x−2)+D(x+2)) + 177·(D(x−3)+D(x+3)) + 102·(D(x−4)+D(x+4)). The window holds the nine most recent accepted samples, and D(x) is the fifth most recent.
- R3: Outputs are produced for the windows completed by the 9th, 11th, 13th, … accepted samples after reset, and for no others.
- R4: out_valid is high exactly four rising edges after the edge that accepts the sample completing an output window: one edge for the window, then fold, product and sum stages.
- R5: A sample is taken only on an edge where in_valid is high; cycles with in_valid low leave the window, the decimation phase and the results unchanged, whatever in_data carries.
- R6: With zsub_en high, bit 0 of every sample is treated as 0, so exact − out_data (bias 2'b00) lies in 0..4585, reaching 4585 when all nine samples are odd.
- R7: bias_sel = 2'b01 adds 2048 to the sum.
- R8: bias_sel = 2'b10 adds 2292 (half the 4585 error span); with zsub_en high, out_data − exact then lies in −2293..2292.
- R9: bias_sel = 2'b11 adds nothing, the same as 2'b00.
- R10: The output width (21 bits by default) holds the largest sum plus the largest bias without wrap: nine samples of 255 with bias 2'b10 give 1171467.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe; in_data is taken on an edge where it is high |
| in_data | input | 8 | Unsigned input sample |
| zsub_en | input | 1 | Force the low input bit to zero |
| bias_sel | input | 2 | Output bias: 00 none, 01 fixed 2048, 10 half span, 11 none |
| out_valid | output | 1 | High for one cycle with each decimated result |
| out_data | output | 21 | Filtered sample plus selected bias |

## Verification
The behaviour hardest to reach from the ports is keeping the decimation phase and the window intact across idle cycles. A skipped or extra shift would still give plausible-looking outputs. The bench therefore repeats the same sample table with an idle cycle carrying a garbage value after each sample, and requires the same results at the same sample positions. The extreme of the zero-substitution error is reached only when every tap is odd. An all-255 stream drives it to exactly 4585 and also gives the largest biased sum for the overflow limit.

// File: rtl/dwt_lp_pkg.sv
// Shared constants, types and sizing functions for the wavelet low-pass stage.
// Assumes a symmetric window of 2*NTAP-1 samples with unsigned coefficients.
package dwt_lp_pkg;

    localparam int unsigned NTAP  = 5;
    localparam int unsigned DEPTH = 2 * NTAP - 1;

    typedef int unsigned coef_arr_t [NTAP];

    typedef enum logic [1:0] {
        BIAS_NONE  = 2'b00,
        BIAS_FIXED = 2'b01,
        BIAS_HALF  = 2'b10,
        BIAS_RSVD  = 2'b11
    } bias_mode_e;

    // Weight applied to a unit error on every tap: centre once, pairs twice.
    function automatic int unsigned weight_sum(coef_arr_t c);
        int unsigned s;
        s = c[0];
        for (int k = 1; k < NTAP; k++) s += 2 * c[k];
        return s;
    endfunction

    // Largest shortfall caused by clearing zs low bits on every sample.
    function automatic int unsigned trunc_err_max(coef_arr_t c, int unsigned zs);
        return weight_sum(c) * ((32'd1 << zs) - 32'd1);
    endfunction

    // Bias that centres the truncation error around zero.
    function automatic int unsigned half_bias(coef_arr_t c, int unsigned zs);
        return trunc_err_max(c, zs) / 2;
    endfunction

    // Bits needed for the largest sum plus the larger of the two biases.
    function automatic int unsigned out_width(int unsigned dw, coef_arr_t c,
                                              int unsigned zs, int unsigned fixed_b);
        longint unsigned top_v;
        longint unsigned b;
        b = (fixed_b > half_bias(c, zs)) ? longint'(fixed_b) : longint'(half_bias(c, zs));
        top_v = ((64'd1 << dw) - 64'd1) * longint'(weight_sum(c)) + b;
        return $clog2(top_v + 64'd1);
    endfunction

endpackage

// File: rtl/dwt_window.sv
// Sample window and decimation control.
// Shifts an accepted sample into a DEPTH-entry window (index 0 newest), counts
// the fill level, and flags every second full window starting with the first.
// Assumes in_data is meaningful only while in_valid is high.
module dwt_window
    import dwt_lp_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [DW-1:0]                in_data,
    output logic [DEPTH-1:0][DW-1:0]     taps,
    output logic                         win_vld
);

    localparam int unsigned FILL_W = $clog2(DEPTH + 1);

    logic [FILL_W-1:0] fill;
    logic              phase;
    logic              full_next;
    logic              emit;

    // Window is complete once this sample lands.
    assign full_next = in_valid && (fill >= FILL_W'(DEPTH - 1));
    // Keep only the even-phase complete windows.
    assign emit      = full_next && !phase;

    // Shift register, fill counter and decimation phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps    <= '0;
            fill    <= '0;
            phase   <= 1'b0;
            win_vld <= 1'b0;
        end else begin
            win_vld <= emit;
            if (in_valid) begin
                taps <= {taps[DEPTH-2:0], in_data};
                if (fill != FILL_W'(DEPTH)) fill <= fill + 1'b1;
            end
            if (full_next) phase <= ~phase;
        end
    end

    // A flagged window always has every entry filled since reset.
    p_full_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> (fill == FILL_W'(DEPTH)));

    // Two flagged windows never follow on consecutive edges.
    p_decimate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |=> !win_vld);

    // Idle cycles leave the window untouched.
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(taps));

endmodule

// File: rtl/dwt_fold.sv
// Symmetric pre-adder with optional low-bit zero substitution.
// Output 0 carries the centre tap; output k carries the sum of the taps k
// positions either side of the centre. One register stage.
module dwt_fold
    import dwt_lp_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned ZS = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0][DW-1:0]     taps,
    input  logic                         win_vld,
    input  logic                         zsub_en,
    output logic [NTAP-1:0][DW:0]        fold,
    output logic                         fold_vld
);

    localparam int unsigned CTR      = NTAP - 1;
    localparam logic [DW-1:0] KEEP   = {DW{1'b1}} << ZS;

    logic [DEPTH-1:0][DW-1:0] used;
    logic [NTAP-1:0][DW:0]    fold_d;

    // Mask the substituted low bits of every tap when requested.
    for (genvar t = 0; t < DEPTH; t++) begin : g_mask
        assign used[t] = zsub_en ? (taps[t] & KEEP) : taps[t];
    end

    // Centre passes through; mirrored neighbours are added pairwise.
    assign fold_d[0] = {1'b0, used[CTR]};
    for (genvar k = 1; k < NTAP; k++) begin : g_pair
        assign fold_d[k] = (DW+1)'(used[CTR-k]) + (DW+1)'(used[CTR+k]);
    end

    // Register folded pairs with their valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fold     <= '0;
            fold_vld <= 1'b0;
        end else begin
            fold     <= fold_d;
            fold_vld <= win_vld;
        end
    end

    // With substitution, centre and outer pair carry no low bits.
    p_zsub_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fold_vld && $past(zsub_en)) |->
        (fold[0][ZS-1:0] == '0 && fold[NTAP-1][ZS-1:0] == '0));

    // The fold stage follows the window stage by one edge.
    p_fold_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fold_vld |-> $past(win_vld));

endmodule

// File: rtl/dwt_mac.sv
// Coefficient multiply and summing stage with output bias.
// Stage one registers the NTAP products, stage two registers their sum plus
// the bias chosen by bias_sel. Assumes OUT_W holds the largest biased sum.
module dwt_mac
    import dwt_lp_pkg::*;
#(
    parameter int unsigned DW         = 8,
    parameter int unsigned COEF_W     = 12,
    parameter coef_arr_t   COEF       = '{1517, 853, 402, 177, 102},
    parameter int unsigned OUT_W      = 21,
    parameter int unsigned FIXED_BIAS = 2048,
    parameter int unsigned HALF_BIAS  = 2292
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTAP-1:0][DW:0]    fold,
    input  logic                     fold_vld,
    input  bias_mode_e               bias_sel,
    output logic [OUT_W-1:0]         sum_out,
    output logic                     out_vld
);

    localparam int unsigned PROD_W = DW + 1 + COEF_W;

    logic [NTAP-1:0][PROD_W-1:0] prod;
    logic                        prod_vld;
    logic [OUT_W-1:0]            acc;
    logic [OUT_W-1:0]            bias_v;

    // One registered multiplier per coefficient.
    for (genvar k = 0; k < NTAP; k++) begin : g_mul
        always_ff @(posedge clk) begin
            if (!rst_n) prod[k] <= '0;
            else        prod[k] <= PROD_W'(fold[k]) * PROD_W'(COEF[k]);
        end
    end

    // Valid flag travelling beside the products.
    always_ff @(posedge clk) begin
        if (!rst_n) prod_vld <= 1'b0;
        else        prod_vld <= fold_vld;
    end

    // Sum of all products.
    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAP; k++) acc = acc + OUT_W'(prod[k]);
    end

    // Bias constant for the current mode; the reserved code adds nothing.
    always_comb begin
        case (bias_sel)
            BIAS_FIXED: bias_v = OUT_W'(FIXED_BIAS);
            BIAS_HALF:  bias_v = OUT_W'(HALF_BIAS);
            default:    bias_v = '0;
        endcase
    end

    // Output register: biased sum and its valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_out <= '0;
            out_vld <= 1'b0;
        end else begin
            sum_out <= acc + bias_v;
            out_vld <= prod_vld;
        end
    end

    // The sum stage follows the product stage by one edge.
    p_sum_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(prod_vld));

    // A fixed-bias result is never below the bias itself.
    p_fixed_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(bias_sel) == BIAS_FIXED) |-> (sum_out >= OUT_W'(FIXED_BIAS)));

    // Adding the bias never wraps the output word.
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prod_vld |-> ({1'b0, acc} + {1'b0, bias_v} == (OUT_W+1)'(acc + bias_v)));

endmodule

// File: rtl/dwt_lowpass.sv
// Top of the symmetric wavelet low-pass stage.
// Window -> symmetric fold -> multiply -> sum with bias; one result for every
// second full window. Mode inputs are expected to stay steady while a stream
// is in flight; reset restarts the window and the decimation phase.
module dwt_lowpass
    import dwt_lp_pkg::*;
#(
    parameter int unsigned DW         = 8,
    parameter int unsigned COEF_W     = 12,
    parameter coef_arr_t   COEF       = '{1517, 853, 402, 177, 102},
    parameter int unsigned ZS         = 1,
    parameter int unsigned FIXED_BIAS = 2048,
    localparam int unsigned HALF_B    = half_bias(COEF, ZS),
    localparam int unsigned OUT_W     = out_width(DW, COEF, ZS, FIXED_BIAS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  logic             zsub_en,
    input  logic [1:0]       bias_sel,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);

    logic [DEPTH-1:0][DW-1:0] taps;
    logic                     win_vld;
    logic [NTAP-1:0][DW:0]    fold;
    logic                     fold_vld;
    bias_mode_e               bias_mode;

    assign bias_mode = bias_mode_e'(bias_sel);

    dwt_window #(.DW(DW)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .taps     (taps),
        .win_vld  (win_vld)
    );

    dwt_fold #(.DW(DW), .ZS(ZS)) u_fold (
        .clk      (clk),
        .rst_n    (rst_n),
        .taps     (taps),
        .win_vld  (win_vld),
        .zsub_en  (zsub_en),
        .fold     (fold),
        .fold_vld (fold_vld)
    );

    dwt_mac #(
        .DW         (DW),
        .COEF_W     (COEF_W),
        .COEF       (COEF),
        .OUT_W      (OUT_W),
        .FIXED_BIAS (FIXED_BIAS),
        .HALF_BIAS  (HALF_B)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .fold     (fold),
        .fold_vld (fold_vld),
        .bias_sel (bias_mode),
        .sum_out  (out_data),
        .out_vld  (out_valid)
    );

    // Every result traces back to an accepted sample four edges earlier.
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 4));

endmodule

// File: tb/dwt_lowpass_bench.sv
`timescale 1ns/1ps
module dwt_lowpass_bench;

    localparam int unsigned DW    = 8;
    localparam int unsigned OUT_W = dwt_lp_pkg::out_width(8, '{1517, 853, 402, 177, 102}, 1, 2048);
    localparam int W0 = 1517, W1 = 853, W2 = 402, W3 = 177, W4 = 102;
    localparam int ERR_MAX = W0 + 2 * (W1 + W2 + W3 + W4);
    localparam int B_FIX   = 2048;
    localparam int B_HALF  = ERR_MAX / 2;

    localparam int NSTIM = 20;
    localparam int STIM [NSTIM] = '{12, 255, 7, 130, 0, 99, 201, 64, 33, 250,
                                    1, 128, 77, 180, 3, 255, 90, 45, 222, 17};
    localparam int NCFG = 7;
    localparam bit    CFG_ZS   [NCFG] = '{0, 0, 1, 0, 1, 0, 0};
    localparam int    CFG_BIAS [NCFG] = '{0, 0, 0, 1, 2, 2, 3};
    localparam bit    CFG_GAP  [NCFG] = '{0, 1, 0, 0, 0, 0, 0};
    localparam string CFG_REQ  [NCFG] = '{"R2", "R5", "R6", "R7", "R8", "R8", "R9"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [DW-1:0]    in_data = '0;
    logic             zsub_en = 1'b0;
    logic [1:0]       bias_sel = 2'b00;
    logic             out_valid;
    logic [OUT_W-1:0] out_data;

    always #2.5 clk = ~clk;

    dwt_lowpass u_dwt_lowpass (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .zsub_en(zsub_en), .bias_sel(bias_sel),
        .out_valid(out_valid), .out_data(out_data)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int got_val [128];
    int got_cyc [128];
    int ngot = 0;
    always @(negedge clk) begin
        if (rst_n && out_valid && ngot < 128) begin
            got_val[ngot] = int'(out_data);
            got_cyc[ngot] = cyc;
            ngot = ngot + 1;
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    int s [64];
    int slen = 0;
    int drive_cyc [64];
    int base = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input longint act, input longint lo, input longint hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    function automatic longint exact(input int idx);
        int c;
        c = idx - 4;
        return longint'(W0 * s[c] + W1 * (s[c-1] + s[c+1]) + W2 * (s[c-2] + s[c+2])
                      + W3 * (s[c-3] + s[c+3]) + W4 * (s[c-4] + s[c+4]));
    endfunction

    function automatic longint bias_of(input int b);
        return (b == 1) ? B_FIX : (b == 2) ? B_HALF : 0;
    endfunction

    task automatic restart(input bit zs, input int b);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; zsub_en = zs; bias_sel = 2'(b);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        base = ngot;
    endtask

    task automatic drive(input bit gap);
        for (int i = 0; i < slen; i++) begin
            in_data = 8'(s[i]); in_valid = 1'b1; drive_cyc[i] = cyc;
            @(negedge clk);
            if (gap) begin
                in_valid = 1'b0; in_data = 8'hA5;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic verify(input bit zs, input int b, input string req);
        int n_exp;
        n_exp = (slen >= 9) ? (slen - 9) / 2 + 1 : 0;
        chk(ngot - base == n_exp, "R3", ngot - base, n_exp);
        for (int j = 0; j < n_exp && j < ngot - base; j++) begin
            int idx;
            longint e;
            longint o;
            idx = 8 + 2 * j;
            e = exact(idx);
            o = longint'(got_val[base + j]);
            if (!zs) chk(o == e + bias_of(b), req, o, e + bias_of(b));
            else     chk_rng(req, o - e, bias_of(b) - ERR_MAX, bias_of(b));
            chk(got_cyc[base + j] == drive_cyc[idx] + 4, "R4",
                got_cyc[base + j], drive_cyc[idx] + 4);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        // R1: reset state, then eight samples give no output.
        restart(0, 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        slen = 8;
        for (int i = 0; i < 8; i++) s[i] = STIM[i];
        drive(0);
        chk(ngot - base == 0, "R1", ngot - base, 0);

        // Table walk: one stream per configuration.
        for (int c = 0; c < NCFG; c++) begin
            slen = NSTIM;
            for (int i = 0; i < NSTIM; i++) s[i] = STIM[i];
            restart(CFG_ZS[c], CFG_BIAS[c]);
            drive(CFG_GAP[c]);
            verify(CFG_ZS[c], CFG_BIAS[c], CFG_REQ[c]);
        end

        // R6 boundary: all odd taps reach the full error span.
        slen = 9;
        for (int i = 0; i < 9; i++) s[i] = 255;
        restart(1, 0);
        drive(0);
        chk(ngot - base == 1, "R6", ngot - base, 1);
        chk(longint'(got_val[base]) == 254 * ERR_MAX, "R6", got_val[base], 254 * ERR_MAX);

        // R10: largest sum with the half-span bias.
        restart(0, 2);
        drive(0);
        chk(ngot - base == 1, "R10", ngot - base, 1);
        chk(longint'(got_val[base]) == 255 * ERR_MAX + B_HALF, "R10",
            got_val[base], 255 * ERR_MAX + B_HALF);

        // R2 boundary: all-zero stream gives zero.
        slen = 11;
        for (int i = 0; i < 11; i++) s[i] = 0;
        restart(0, 0);
        drive(0);
        chk(ngot - base == 2, "R3", ngot - base, 2);
        chk(got_val[base] == 0 && got_val[base + 1] == 0, "R2", got_val[base], 0);

        done = 1;
        summary();
    end

endmodule